// File: doc/BRIEF.md
# Parallel 1D Convolution Layer Engine

This block evaluates a single one-dimensional convolution layer over multi-channel waveform samples in signed 16-bit fixed point. The input feature map, the filter kernels and the per-filter biases are presented as flat register vectors. The vectors are held by the surrounding register bank, and the engine reads any element in the same cycle. The engine emits its output feature map as a series of wide write beats aimed at an output buffer.

A grid of multiply-accumulate lanes works on several output filters and several sliding-window positions at once. Each lane can multiply a configurable number of kernel taps in parallel. Input channels are always walked one at a time into the same accumulator. Once the last input channel has been summed, the bias is added, and the sum is rounded and clamped back to 16 bits. A single-cycle `start` launches a run, and `done` marks its end.

Top module: `conv1d_engine`

## Requirements
- R1: Convolution is valid-mode with stride 1, so output positions run from 0 to LEN_IN-KLEN. Output (f,p) equals the rounded, saturated value of bias[f]·2^FRAC plus the sum over channels c and taps k of x[c][p+k]·w[f][c][k]. All operands are signed 16-bit with FRAC fraction bits. Flat layouts: x at element c·LEN_IN+p, w at element (f·CIN+c)·KLEN+k, bias at element f, each 16 bits wide, with element 0 in the least significant bits.
- R2: Rescaling adds 2^(FRAC-1) and then shifts right arithmetically by FRAC, so an exact half rounds toward positive infinity.
- R3: A rescaled result above 32767 is output as 32767, and one below -32768 is output as -32768. The output never wraps.
- R4: The bias is added exactly once per output sample, regardless of the number of input channels.
- R5: A run produces exactly (LEN_OUT/PW)·(COUT/PF) write beats, with `wr_en` high for one cycle each. Each beat carries PF filters × PW positions. Lane fi·PW+wi of `wr_data` holds filter `wr_filt`+fi at position `wr_pos`+wi. Positions ascend inside a filter group, and filter groups ascend.
- R6: With N = (KLEN/PK)·CIN·(LEN_OUT/PW)·(COUT/PF), `done` rises on the (N+1)th rising edge after the edge that accepts `start`. The last write beat is in the cycle just before `done`.
- R7: `done` is high for exactly one clock cycle per run.
- R8: `start` is ignored while `busy` is high. A pulse during a run changes neither the number of write beats, nor their contents, nor the timing of `done`.
- R9: After synchronous reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a layer run when idle |
| in_flat | input | CIN·LEN_IN·16 | Input feature map |
| wgt_flat | input | COUT·CIN·KLEN·16 | Kernel weights |
| bias_flat | input | COUT·16 | Per-filter bias |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| wr_en | output | 1 | Output write beat valid |
| wr_filt | output | 8 | First filter index of the beat |
| wr_pos | output | 8 | First position index of the beat |
| wr_data | output | PF·PW·16 | Output samples, one per lane |

## Verification
The bench drives a lone sample through a weight of plus or minus one half, so that the result lands exactly on a rounding tie. A design that truncates or rounds away from zero gives the wrong least significant bit on one of the two signs. Full-scale inputs of both signs push the accumulator far outside the 16-bit range, and a design that drops the clamp returns wrapped values. A test with zero input and a random bias shows a bias that is added once per channel instead of once per sample. A `start` pulse injected mid-run shows a sequencer that restarts, because it gives extra beats, a late `done` or corrupted sums. Random runs over several operand ranges compare every lane, the beat order and the run latency against a reference model in the bench.

// File: rtl/conv1d_pkg.sv
package conv1d_pkg;

    localparam int DATA_W = 16;
    localparam int ACC_W  = 48;
    localparam int IDX_W  = 8;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [IDX_W-1:0]         idx_t;

    typedef struct packed {
        logic valid;     // a MAC step happens this cycle
        logic first;     // first step of an output sample
        logic last;      // last channel/tap step of an output sample
        logic last_all;  // last step of the whole run
    } step_ctl_t;

    localparam acc_t SAT_HI = (acc_t'(1) <<< (DATA_W-1)) - acc_t'(1);
    localparam acc_t SAT_LO = -(acc_t'(1) <<< (DATA_W-1));

    // Round half toward +inf, then clamp to the sample range.
    function automatic sample_t round_sat(acc_t v, int frac);
        acc_t r;
        r = (v + (acc_t'(1) <<< (frac-1))) >>> frac;
        if (r > SAT_HI)      return sample_t'(SAT_HI);
        else if (r < SAT_LO) return sample_t'(SAT_LO);
        else                 return sample_t'(r);
    endfunction

endpackage

// File: rtl/conv1d_seq.sv
module conv1d_seq
    import conv1d_pkg::*;
#(
    parameter int SK  = 2,
    parameter int CIN = 2,
    parameter int SW  = 5,
    parameter int SF  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output logic      busy,
    output idx_t      k_idx,
    output idx_t      c_idx,
    output idx_t      w_idx,
    output idx_t      f_idx,
    output step_ctl_t ctl
);

    logic k_end, c_end, w_end, f_end;

    assign k_end = (k_idx == idx_t'(SK-1));
    assign c_end = (c_idx == idx_t'(CIN-1));
    assign w_end = (w_idx == idx_t'(SW-1));
    assign f_end = (f_idx == idx_t'(SF-1));

    always_comb begin
        ctl.valid    = busy;
        ctl.first    = (k_idx == '0) && (c_idx == '0);
        ctl.last     = k_end && c_end;
        ctl.last_all = k_end && c_end && w_end && f_end;
    end

    // Loop nest, outer to inner: filter group, window group, channel, tap group.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            k_idx <= '0;
            c_idx <= '0;
            w_idx <= '0;
            f_idx <= '0;
        end else if (!busy) begin
            busy  <= start;
            k_idx <= '0;
            c_idx <= '0;
            w_idx <= '0;
            f_idx <= '0;
        end else if (!k_end) begin
            k_idx <= k_idx + 1'b1;
        end else begin
            k_idx <= '0;
            if (!c_end) begin
                c_idx <= c_idx + 1'b1;
            end else begin
                c_idx <= '0;
                if (!w_end) begin
                    w_idx <= w_idx + 1'b1;
                end else begin
                    w_idx <= '0;
                    if (!f_end) f_idx <= f_idx + 1'b1;
                    else        busy  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/conv1d_lane.sv
module conv1d_lane
    import conv1d_pkg::*;
#(
    parameter int PK   = 2,
    parameter int FRAC = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   first,
    input  logic                   last,
    input  logic [PK*DATA_W-1:0]   x_taps,
    input  logic [PK*DATA_W-1:0]   w_taps,
    input  sample_t                bias,
    output sample_t                y
);

    acc_t acc;
    acc_t psum;
    acc_t acc_new;

    always_comb begin
        psum = '0;
        for (int j = 0; j < PK; j++) begin
            psum = psum + acc_t'(sample_t'(x_taps[j*DATA_W +: DATA_W]))
                        * acc_t'(sample_t'(w_taps[j*DATA_W +: DATA_W]));
        end
        acc_new = (first ? acc_t'(0) : acc) + psum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            y   <= '0;
        end else if (en) begin
            acc <= acc_new;
            if (last) y <= round_sat(acc_new + (acc_t'(bias) <<< FRAC), FRAC);
        end
    end

endmodule

// File: rtl/conv1d_engine.sv
module conv1d_engine
    import conv1d_pkg::*;
#(
    parameter int FRAC   = 8,
    parameter int KLEN   = 4,
    parameter int CIN    = 2,
    parameter int COUT   = 4,
    parameter int LEN_IN = 13,
    parameter int PK     = 2,
    parameter int PW     = 2,
    parameter int PF     = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 start,
    input  logic [CIN*LEN_IN*DATA_W-1:0]         in_flat,
    input  logic [COUT*CIN*KLEN*DATA_W-1:0]      wgt_flat,
    input  logic [COUT*DATA_W-1:0]               bias_flat,
    output logic                                 busy,
    output logic                                 done,
    output logic                                 wr_en,
    output logic [IDX_W-1:0]                     wr_filt,
    output logic [IDX_W-1:0]                     wr_pos,
    output logic [PF*PW*DATA_W-1:0]              wr_data
);

    localparam int LEN_OUT = LEN_IN - KLEN + 1;
    localparam int SK      = KLEN / PK;
    localparam int SW      = LEN_OUT / PW;
    localparam int SF      = COUT / PF;

    idx_t      k_idx, c_idx, w_idx, f_idx;
    step_ctl_t ctl;
    logic      fin_q;

    conv1d_seq #(.SK(SK), .CIN(CIN), .SW(SW), .SF(SF)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .k_idx (k_idx),
        .c_idx (c_idx),
        .w_idx (w_idx),
        .f_idx (f_idx),
        .ctl   (ctl)
    );

    for (genvar fi = 0; fi < PF; fi++) begin : g_filt
        for (genvar wi = 0; wi < PW; wi++) begin : g_win
            logic [PK*DATA_W-1:0] x_taps;
            logic [PK*DATA_W-1:0] w_taps;
            sample_t              bias;
            sample_t              y;

            always_comb begin
                int pos, xi, wx, f;
                f    = int'(f_idx) * PF + fi;
                bias = sample_t'(bias_flat[f*DATA_W +: DATA_W]);
                for (int j = 0; j < PK; j++) begin
                    pos = int'(w_idx) * PW + wi + int'(k_idx) * PK + j;
                    xi  = int'(c_idx) * LEN_IN + pos;
                    wx  = (f * CIN + int'(c_idx)) * KLEN + int'(k_idx) * PK + j;
                    x_taps[j*DATA_W +: DATA_W] = in_flat[xi*DATA_W +: DATA_W];
                    w_taps[j*DATA_W +: DATA_W] = wgt_flat[wx*DATA_W +: DATA_W];
                end
            end

            conv1d_lane #(.PK(PK), .FRAC(FRAC)) u_lane (
                .clk    (clk),
                .rst    (rst),
                .en     (ctl.valid),
                .first  (ctl.first),
                .last   (ctl.last),
                .x_taps (x_taps),
                .w_taps (w_taps),
                .bias   (bias),
                .y      (y)
            );

            assign wr_data[(fi*PW+wi)*DATA_W +: DATA_W] = y;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_filt <= '0;
            wr_pos  <= '0;
            fin_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            wr_en <= ctl.valid && ctl.last;
            fin_q <= ctl.valid && ctl.last_all;
            done  <= fin_q;
            if (ctl.valid && ctl.last) begin
                wr_filt <= idx_t'(int'(f_idx) * PF);
                wr_pos  <= idx_t'(int'(w_idx) * PW);
            end
        end
    end

endmodule

// File: rtl/conv1d_engine_chk.sv
module conv1d_engine_chk
    import conv1d_pkg::*;
#(
    parameter int LEN_OUT = 10,
    parameter int COUT    = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       wr_en,
    input logic [IDX_W-1:0] wr_filt,
    input logic [IDX_W-1:0] wr_pos
);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) && !wr_en && !busy));

    assert_last_beat_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wr_en);

    assert_accept_start_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    assert_beat_range_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((int'(wr_pos) < LEN_OUT) && (int'(wr_filt) < COUT)));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!done && !wr_en));

endmodule

bind conv1d_engine conv1d_engine_chk #(.LEN_OUT(LEN_OUT), .COUT(COUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .wr_filt (wr_filt),
    .wr_pos  (wr_pos)
);

// File: tb/conv1d_engine_bench.sv
module conv1d_engine_bench;

    localparam int FRAC    = 8;
    localparam int KLEN    = 4;
    localparam int CIN     = 2;
    localparam int COUT    = 4;
    localparam int LEN_IN  = 13;
    localparam int PK      = 2;
    localparam int PW      = 2;
    localparam int PF      = 2;
    localparam int LEN_OUT = LEN_IN - KLEN + 1;
    localparam int SW      = LEN_OUT / PW;
    localparam int SF      = COUT / PF;
    localparam int NSTEP   = (KLEN / PK) * CIN * SW * SF;
    localparam int NBEAT   = SW * SF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CIN*LEN_IN*16-1:0]    in_flat = '0;
    logic [COUT*CIN*KLEN*16-1:0] wgt_flat = '0;
    logic [COUT*16-1:0]          bias_flat = '0;
    logic        busy, done, wr_en;
    logic [7:0]  wr_filt, wr_pos;
    logic [PF*PW*16-1:0] wr_data;

    logic signed [15:0] xs [CIN][LEN_IN];
    logic signed [15:0] ws [COUT][CIN][KLEN];
    logic signed [15:0] bs [COUT];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    conv1d_engine #(.FRAC(FRAC), .KLEN(KLEN), .CIN(CIN), .COUT(COUT),
                    .LEN_IN(LEN_IN), .PK(PK), .PW(PW), .PF(PF)) u_conv1d_engine (
        .clk(clk), .rst(rst), .start(start), .in_flat(in_flat),
        .wgt_flat(wgt_flat), .bias_flat(bias_flat), .busy(busy), .done(done),
        .wr_en(wr_en), .wr_filt(wr_filt), .wr_pos(wr_pos), .wr_data(wr_data)
    );

    function automatic logic signed [15:0] ref_out(int f, int p);
        longint acc;
        acc = longint'(bs[f]) <<< FRAC;
        for (int c = 0; c < CIN; c++)
            for (int k = 0; k < KLEN; k++)
                acc += longint'(xs[c][p+k]) * longint'(ws[f][c][k]);
        acc = (acc + (longint'(1) <<< (FRAC-1))) >>> FRAC;
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return 16'(acc);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(int xr, int wr, int br);
        for (int c = 0; c < CIN; c++)
            for (int p = 0; p < LEN_IN; p++)
                xs[c][p] = 16'($signed($urandom_range(2*xr)) - xr);
        for (int f = 0; f < COUT; f++) begin
            bs[f] = 16'($signed($urandom_range(2*br)) - br);
            for (int c = 0; c < CIN; c++)
                for (int k = 0; k < KLEN; k++)
                    ws[f][c][k] = 16'($signed($urandom_range(2*wr)) - wr);
        end
    endtask

    task automatic run(string req, bit poke);
        int cyc, nwr, done_cyc;
        bit got_done;
        for (int c = 0; c < CIN; c++)
            for (int p = 0; p < LEN_IN; p++)
                in_flat[(c*LEN_IN+p)*16 +: 16] = xs[c][p];
        for (int f = 0; f < COUT; f++) begin
            bias_flat[f*16 +: 16] = bs[f];
            for (int c = 0; c < CIN; c++)
                for (int k = 0; k < KLEN; k++)
                    wgt_flat[((f*CIN+c)*KLEN+k)*16 +: 16] = ws[f][c][k];
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1; nwr = 0; done_cyc = -1; got_done = 0;
        while (!got_done && cyc < NSTEP + 20) begin
            if (wr_en) begin
                int fexp, pexp, bad_l;
                logic signed [15:0] a, e;
                fexp = (nwr / SW) * PF;
                pexp = (nwr % SW) * PW;
                check(int'(wr_filt) == fexp && int'(wr_pos) == pexp, "R5",
                      "beat filter/position", wr_filt * 1000 + wr_pos, fexp * 1000 + pexp);
                bad_l = -1; a = 0; e = 0;
                for (int fi = 0; fi < PF; fi++)
                    for (int wi = 0; wi < PW; wi++) begin
                        logic signed [15:0] av, ev;
                        av = wr_data[(fi*PW+wi)*16 +: 16];
                        ev = ref_out(fexp + fi, pexp + wi);
                        if (av !== ev && bad_l < 0) begin
                            bad_l = fi*PW+wi; a = av; e = ev;
                        end
                    end
                check(bad_l < 0, req, "lane data", a, e);
                nwr++;
            end
            if (done) begin
                got_done = 1;
                done_cyc = cyc;
            end
            if (poke && cyc == 10) begin
                check(busy == 1'b1, "R8", "busy during run", busy, 1);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(nwr == NBEAT, "R5", "beat count", nwr, NBEAT);
        check(done_cyc == NSTEP + 2, "R6", "done latency", done_cyc, NSTEP + 2);
        check(done == 1'b0 && busy == 1'b0, "R7", "done width", done, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2741));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !wr_en, "R9", "reset outputs", {busy, done, wr_en}, 0);

        // R1: random operands, small and mid range
        for (int t = 0; t < 3; t++) begin
            fill(2048, 2048, 4000);
            run("R1", 0);
        end
        // R3: full-range random operands, frequent clamping
        for (int t = 0; t < 2; t++) begin
            fill(32767, 32767, 32767);
            run("R3", 0);
        end
        // R3: directed positive and negative saturation
        fill(0, 0, 0);
        for (int c = 0; c < CIN; c++) for (int p = 0; p < LEN_IN; p++) xs[c][p] = 16'sd32767;
        for (int f = 0; f < COUT; f++) for (int c = 0; c < CIN; c++)
            for (int k = 0; k < KLEN; k++) ws[f][c][k] = (f % 2 == 0) ? 16'sd32767 : -16'sd32768;
        run("R3", 0);
        // R2: exact half ties of both signs
        fill(0, 0, 0);
        xs[0][0] = 16'sd1;
        for (int f = 0; f < COUT; f++) ws[f][0][0] = (f % 2 == 0) ? 16'sd128 : -16'sd128;
        run("R2", 0);
        check(ref_out(0, 0) == 16'sd1 && ref_out(1, 0) == 16'sd0, "R2",
              "tie reference", ref_out(1, 0), 0);
        // R4: zero input, output must equal bias exactly once
        fill(0, 16000, 30000);
        run("R4", 0);
        // R8: start pulse injected during a run
        fill(4000, 4000, 4000);
        run("R8", 1);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule